// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block lets synchronous logic program one word, erase one sector or erase a whole part in an asynchronous parallel flash device. A host presents a command code, a target address and a data word on a valid/ready request port. The block then drives the flash bus through the unlock write sequence, holding every strobe for a whole number of clock cycles. Each of those counts is a parameter, set by rounding the device's nanosecond minimums up to clock periods.

Once the last write is issued, the block does not wait for a fixed time. It reads the target location again and again and watches the status bit, bit 7. While the internal operation runs, the device returns the inverse of the expected value on that bit; the operation has finished once the bit reads back as expected. A read budget bounds the loop. The operation ends with a one-cycle `done` pulse, or a one-cycle `err` pulse if the budget runs out or the command code is reserved.

The sequencer runs through these states. SQ_IDLE moves on accept to SQ_WR_GO, or to SQ_FAIL for a reserved code. SQ_WR_GO moves to SQ_WR_WAIT. SQ_WR_WAIT moves on bus finish to SQ_WR_GO for the next step, or to SQ_RD_GO after the final step. SQ_RD_GO moves to SQ_RD_WAIT. SQ_RD_WAIT moves on bus finish to SQ_OK on a match, to SQ_FAIL when the budget is spent, and otherwise back to SQ_RD_GO. SQ_OK and SQ_FAIL each return to SQ_IDLE.

The bus engine has its own states. A write goes BC_IDLE, BC_SETUP, BC_WE_LOW, BC_WE_HIGH and back to BC_IDLE. A read goes BC_IDLE, BC_OE_WAIT, BC_OE_LOW, BC_RD_END and back to BC_IDLE.

Top module: `flash_seq`

## Requirements
- R1: After reset, and whenever the block is idle, `req_ready` is 1 and `busy`, `done` and `err` are 0. The bus is parked with `fl_ce_n`, `fl_we_n` and `fl_oe_n` at 1 and `fl_dq_oe` at 0.
- R2: Command code 0 (program) makes exactly four writes as (address, data) pairs: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (target address, request data).
- R3: Command code 1 (sector erase) makes exactly six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (target address, 30h).
- R4: Command code 2 (chip erase) makes the same six writes as R3, except that the last one is (5555h, 10h).
- R5: Every low pulse on `fl_we_n` lasts exactly T_WP clock cycles.
- R6: Within one operation, `fl_we_n` stays high for at least T_WPH cycles between two pulses. Falling edges of `fl_we_n` are at least T_WC cycles apart.
- R7: While `fl_we_n` is low, `fl_ce_n` is low, `fl_dq_oe` is 1, and `fl_addr` and `fl_dout` do not change.
- R8: `fl_oe_n` goes low only after at least T_OEH cycles with `fl_ce_n` low and `fl_oe_n` high. While `fl_oe_n` is low, `fl_we_n` is high and `fl_dq_oe` is 0.
- R9: After the last write, the block reads the target address until read bit 7 equals the expected value, then pulses `done`. The expected value is bit 7 of the request data for a program and 1 for either erase.
- R10: If POLL_LIMIT status reads all miss, the block pulses `err` after the last one and makes no further bus cycles. A match on read number POLL_LIMIT still gives `done`.
- R11: A request presented while the block is busy is not accepted: `req_ready` stays 0 and no extra bus cycles appear.
- R12: `done` and `err` each last one cycle and are never high together. `busy` falls in the same cycle that one of them rises.
- R13: Command code 3 is reserved. It gives an `err` pulse with no bus cycle at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_cmd | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | AW | Target word or sector address |
| req_data | input | DW | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| err | output | 1 | One-cycle pulse: timeout or reserved code |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Data toward the flash |
| fl_din | input | DW | Data from the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dout` |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
A step counter that skips a value or stops early shows at the bus within one write cycle: the logged (address, data) pair is wrong, or the write count at `done` is off. A bus engine counter loaded with the wrong reload value changes the measured `fl_we_n` low width or high gap on the very next pulse. A wrong poll comparison or a wrong budget compare shows up as `done` or `err` arriving on the wrong read, or as the wrong one of the two. That is checked at exactly POLL_LIMIT−1 and at POLL_LIMIT failing reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_RSVD = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_WR_GO, SQ_WR_WAIT, SQ_RD_GO, SQ_RD_WAIT, SQ_OK, SQ_FAIL
    } sq_state_e;

    typedef enum logic [2:0] {
        BC_IDLE, BC_SETUP, BC_WE_LOW, BC_WE_HIGH, BC_OE_WAIT, BC_OE_LOW, BC_RD_END
    } bc_state_e;

    localparam logic [15:0] ADR_KEY_A = 16'h5555;
    localparam logic [15:0] ADR_KEY_B = 16'h2AAA;
    localparam logic [7:0]  BYTE_K1    = 8'hAA;
    localparam logic [7:0]  BYTE_K2    = 8'h55;
    localparam logic [7:0]  BYTE_PROG  = 8'hA0;
    localparam logic [7:0]  BYTE_ERASE = 8'h80;
    localparam logic [7:0]  BYTE_CHIP  = 8'h10;
    localparam logic [7:0]  BYTE_SECT  = 8'h30;
    localparam int          STATUS_BIT = 7;

endpackage

// File: rtl/flash_seq_step.sv
module flash_seq_step
    import flash_seq_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 8
) (
    input  op_e           op,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] tgt_data,
    output logic [AW-1:0] st_addr,
    output logic [DW-1:0] st_data,
    output logic          st_last
);
    localparam logic [AW-1:0] A_KEY = AW'(ADR_KEY_A);
    localparam logic [AW-1:0] B_KEY = AW'(ADR_KEY_B);

    always_comb begin
        st_addr = A_KEY;
        st_data = DW'(BYTE_K1);
        case (idx)
            3'd0: begin st_addr = A_KEY; st_data = DW'(BYTE_K1); end
            3'd1: begin st_addr = B_KEY; st_data = DW'(BYTE_K2); end
            3'd2: begin
                st_addr = A_KEY;
                st_data = (op == OP_PROG) ? DW'(BYTE_PROG) : DW'(BYTE_ERASE);
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    st_addr = tgt_addr;
                    st_data = tgt_data;
                end else begin
                    st_addr = A_KEY;
                    st_data = DW'(BYTE_K1);
                end
            end
            3'd4: begin st_addr = B_KEY; st_data = DW'(BYTE_K2); end
            default: begin
                if (op == OP_CHIP) begin
                    st_addr = A_KEY;
                    st_data = DW'(BYTE_CHIP);
                end else begin
                    st_addr = tgt_addr;
                    st_data = DW'(BYTE_SECT);
                end
            end
        endcase
    end

    assign st_last = (op == OP_PROG) ? (idx == 3'd3) : (idx == 3'd5);

endmodule

// File: rtl/flash_seq_bus.sv
module flash_seq_bus
    import flash_seq_pkg::*;
#(
    parameter int AW    = 21,
    parameter int DW    = 8,
    parameter int T_WP  = 12,
    parameter int T_WPH = 5,
    parameter int T_WC  = 23,
    parameter int T_OEH = 3,
    parameter int T_RD  = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_wr,
    input  logic          go_rd,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    output logic          fin,
    output logic [DW-1:0] rd_word,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int WP_C  = (T_WP  < 1) ? 1 : T_WP;
    localparam int OEH_C = (T_OEH < 1) ? 1 : T_OEH;
    localparam int RD_C  = (T_RD  < 1) ? 1 : T_RD;
    localparam int WHI_R = (T_WC - WP_C > T_WPH) ? (T_WC - WP_C) : T_WPH;
    localparam int WHI_C = (WHI_R < 1) ? 1 : WHI_R;
    localparam int M1    = (WP_C > WHI_C) ? WP_C : WHI_C;
    localparam int M2    = (OEH_C > RD_C) ? OEH_C : RD_C;
    localparam int CMAX  = (M1 > M2) ? M1 : M2;
    localparam int CW    = $clog2(CMAX + 1);

    bc_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q, rd_q;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BC_IDLE: begin
                if (go_wr) begin
                    st_d = BC_SETUP;
                end else if (go_rd) begin
                    st_d  = BC_OE_WAIT;
                    cnt_d = CW'(OEH_C - 1);
                end
            end
            BC_SETUP: begin
                st_d  = BC_WE_LOW;
                cnt_d = CW'(WP_C - 1);
            end
            BC_WE_LOW: begin
                if (cnt_q == '0) begin
                    st_d  = BC_WE_HIGH;
                    cnt_d = CW'(WHI_C - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BC_WE_HIGH: begin
                if (cnt_q == '0) st_d = BC_IDLE;
                else             cnt_d = cnt_q - 1'b1;
            end
            BC_OE_WAIT: begin
                if (cnt_q == '0) begin
                    st_d  = BC_OE_LOW;
                    cnt_d = CW'(RD_C - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            BC_OE_LOW: begin
                if (cnt_q == '0) st_d = BC_RD_END;
                else             cnt_d = cnt_q - 1'b1;
            end
            BC_RD_END: st_d = BC_IDLE;
            default:   st_d = BC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= BC_IDLE;
            cnt_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            rd_q   <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (st_q == BC_IDLE && (go_wr || go_rd)) begin
                addr_q <= in_addr;
                data_q <= in_data;
            end
            if (st_q == BC_OE_LOW) rd_q <= fl_din;
        end
    end

    always_comb begin
        fin      = ((st_q == BC_WE_HIGH) && (cnt_q == '0)) || (st_q == BC_RD_END);
        fl_we_n  = (st_q != BC_WE_LOW);
        fl_oe_n  = (st_q != BC_OE_LOW);
        fl_ce_n  = (st_q == BC_IDLE);
        fl_dq_oe = (st_q == BC_SETUP) || (st_q == BC_WE_LOW) || (st_q == BC_WE_HIGH);
        fl_addr  = addr_q;
        fl_dout  = data_q;
        rd_word  = rd_q;
    end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int AW         = 21,
    parameter int DW         = 8,
    parameter int T_WP       = 12,
    parameter int T_WPH      = 5,
    parameter int T_WC       = 23,
    parameter int T_OEH      = 3,
    parameter int T_RD       = 23,
    parameter int POLL_LIMIT = 4096
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_cmd,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    input  logic [DW-1:0] fl_din,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    sq_state_e     state_q, state_d;
    op_e           op_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [2:0]    step_q;
    logic [PW-1:0] poll_q;

    logic [AW-1:0] st_addr, bus_addr;
    logic [DW-1:0] st_data, rd_word;
    logic          st_last, fin, go_wr, go_rd, exp_bit, hit, spent;

    flash_seq_step #(.AW(AW), .DW(DW)) u_step (
        .op(op_q), .idx(step_q), .tgt_addr(addr_q), .tgt_data(data_q),
        .st_addr(st_addr), .st_data(st_data), .st_last(st_last)
    );

    flash_seq_bus #(
        .AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH), .T_WC(T_WC),
        .T_OEH(T_OEH), .T_RD(T_RD)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_rd(go_rd),
        .in_addr(bus_addr), .in_data(st_data), .fin(fin), .rd_word(rd_word),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    assign exp_bit = (op_q == OP_PROG) ? data_q[STATUS_BIT] : 1'b1;
    assign hit     = (rd_word[STATUS_BIT] == exp_bit);
    assign spent   = (poll_q == PW'(POLL_LIMIT - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:    if (req_valid) state_d = (op_e'(req_cmd) == OP_RSVD) ? SQ_FAIL : SQ_WR_GO;
            SQ_WR_GO:   state_d = SQ_WR_WAIT;
            SQ_WR_WAIT: if (fin) state_d = st_last ? SQ_RD_GO : SQ_WR_GO;
            SQ_RD_GO:   state_d = SQ_RD_WAIT;
            SQ_RD_WAIT: if (fin) state_d = hit ? SQ_OK : (spent ? SQ_FAIL : SQ_RD_GO);
            SQ_OK:      state_d = SQ_IDLE;
            SQ_FAIL:    state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
            poll_q <= '0;
        end else begin
            if (state_q == SQ_IDLE && req_valid) begin
                op_q   <= op_e'(req_cmd);
                addr_q <= req_addr;
                data_q <= req_data;
                step_q <= '0;
                poll_q <= '0;
            end
            if (state_q == SQ_WR_WAIT && fin && !st_last) step_q <= step_q + 3'd1;
            if (state_q == SQ_RD_WAIT && fin) poll_q <= poll_q + 1'b1;
        end
    end

    always_comb begin
        req_ready = (state_q == SQ_IDLE);
        busy      = !(state_q == SQ_IDLE || state_q == SQ_OK || state_q == SQ_FAIL);
        done      = (state_q == SQ_OK);
        err       = (state_q == SQ_FAIL);
        go_wr     = (state_q == SQ_WR_GO);
        go_rd     = (state_q == SQ_RD_GO);
        bus_addr  = go_rd ? addr_q : st_addr;
    end

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW    = 21,
    parameter int DW    = 8,
    parameter int T_WP  = 12,
    parameter int T_WPH = 5,
    parameter int T_WC  = 23,
    parameter int T_OEH = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_dout,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);
    logic [15:0] low_run, high_run, per_run, oeh_run;
    logic        prev_we, seen_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run   <= '0;
            high_run  <= '0;
            per_run   <= '0;
            oeh_run   <= '0;
            prev_we   <= 1'b1;
            seen_fall <= 1'b0;
        end else begin
            prev_we <= fl_we_n;
            if (!fl_we_n) begin
                high_run <= '0;
                if (low_run != '1) low_run <= low_run + 1'b1;
            end else begin
                low_run <= '0;
                if (high_run != '1) high_run <= high_run + 1'b1;
            end
            if (prev_we && !fl_we_n)  per_run <= 16'd1;
            else if (per_run != '1)   per_run <= per_run + 1'b1;
            if (!busy)                         seen_fall <= 1'b0;
            else if (prev_we && !fl_we_n)      seen_fall <= 1'b1;
            if (fl_oe_n && !fl_ce_n) begin
                if (oeh_run != '1) oeh_run <= oeh_run + 1'b1;
            end else begin
                oeh_run <= '0;
            end
        end
    end

    AST_WE_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (low_run == 16'(T_WP))); // R5
    AST_WE_HIGH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_we_n) && seen_fall) |-> (high_run >= 16'(T_WPH))); // R6
    AST_WE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fl_we_n) && seen_fall) |-> (per_run >= 16'(T_WC))); // R6
    AST_WR_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R7
    AST_WR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (fl_dq_oe && !fl_ce_n)); // R7
    AST_OE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_oe_n) |-> (oeh_run >= 16'(T_OEH))); // R8
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (!fl_dq_oe && fl_we_n && !fl_ce_n)); // R8
    AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && fl_ce_n && fl_we_n && fl_oe_n)); // R1
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R12
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err)); // R12
    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |=> (!done && !err && req_ready)); // R12

endmodule

bind flash_seq flash_seq_chk #(
    .AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH), .T_WC(T_WC), .T_OEH(T_OEH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
    .err(err), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/flash_seq_tb.sv
module flash_seq_tb;
    localparam int AW = 21, DW = 8;
    localparam int T_WP = 3, T_WPH = 2, T_WC = 8, T_OEH = 2, T_RD = 3, POLL_LIMIT = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0, req_valid = 1'b0;
    logic [1:0]    req_cmd = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, busy, done, err, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dout, fl_din;

    flash_seq #(.AW(AW), .DW(DW), .T_WP(T_WP), .T_WPH(T_WPH), .T_WC(T_WC),
                .T_OEH(T_OEH), .T_RD(T_RD), .POLL_LIMIT(POLL_LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data), .busy(busy),
        .done(done), .err(err), .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_din(fl_din),
        .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    int n_run = 0, n_fail = 0;

    // flash model and bus monitor, sampled on falling clock edges
    logic exp7 = 1'b0;
    int   pend_n = 0, clr_tog = 0, clr_seen = 0;
    int   wr_n = 0, rd_n = 0, contention = 0;
    int   min_low = 1000, min_high = 1000, min_per = 1000;
    int   low_run = 0, high_run = 0, per_run = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1, have_fall = 1'b0;
    logic [AW+DW-1:0] wlog [0:15];

    always @(negedge clk) begin
        if (clr_tog != clr_seen) begin
            clr_seen = clr_tog;
            wr_n = 0; rd_n = 0; contention = 0; have_fall = 1'b0;
            min_low = 1000; min_high = 1000; min_per = 1000;
        end
        if (!fl_we_n) begin
            if (prev_we) begin
                if (have_fall && per_run < min_per)   min_per = per_run;
                if (have_fall && high_run < min_high) min_high = high_run;
                have_fall = 1'b1; per_run = 0; low_run = 0;
            end
            low_run++;
        end else begin
            if (!prev_we) begin
                if (low_run < min_low) min_low = low_run;
                wlog[wr_n % 16] = {fl_addr, fl_dout};
                wr_n++;
                high_run = 0;
            end
            high_run++;
        end
        per_run++;
        if (!fl_oe_n && fl_dq_oe) contention++;
        if (fl_oe_n && !prev_oe) rd_n++;
        prev_we = fl_we_n;
        prev_oe = fl_oe_n;
    end

    assign fl_din = fl_oe_n ? '0 : ((rd_n < pend_n) ? {~exp7, 7'h15} : {exp7, 7'h6A});

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int ent(input int a, input int d);
        logic [AW+DW-1:0] v;
        v = {AW'(a), DW'(d)};
        return int'(v);
    endfunction

    task automatic start_op(input logic [1:0] cmd, input int addr, input int data,
                            input logic e7, input int pend);
        clr_tog++;
        exp7 = e7;
        pend_n = pend;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = AW'(addr); req_data = DW'(data);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
    endtask

    task automatic timing_checks(input string who);
        chk({"R5 WE low width ", who}, min_low, T_WP);
        chk({"R6 WE high gap ", who}, int'(min_high >= T_WPH), 1);
        chk({"R6 write period ", who}, int'(min_per >= T_WC), 1);
        chk({"R8 no contention ", who}, contention, 0);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 busy after reset", busy, 0);
        chk("R1 done/err after reset", {done, err}, 0);
        chk("R1 bus parked", {fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    endtask

    task automatic t_program(input int addr, input int data, input int pend);
        start_op(2'd0, addr, data, data[7], pend);
        wait_end();
        chk("R9 program done", done, 1);
        chk("R12 program no err", err, 0);
        chk("R12 busy low at done", busy, 0);
        @(negedge clk);
        chk("R12 done one cycle", done, 0);
        chk("R1 ready after program", req_ready, 1);
        chk("R2 program write count", wr_n, 4);
        chk("R2 write 0", wlog[0], ent(16'h5555, 8'hAA));
        chk("R2 write 1", wlog[1], ent(16'h2AAA, 8'h55));
        chk("R2 write 2", wlog[2], ent(16'h5555, 8'hA0));
        chk("R2 write 3 target", wlog[3], ent(addr, data));
        chk("R9 program poll reads", rd_n, pend + 1);
        timing_checks("program");
    endtask

    task automatic t_erase(input logic chip, input int addr, input int pend);
        start_op(chip ? 2'd2 : 2'd1, addr, 8'h00, 1'b1, pend);
        wait_end();
        chk("R9 erase done", done, 1);
        chk("R12 erase no err", err, 0);
        @(negedge clk);
        chk(chip ? "R4 write count" : "R3 write count", wr_n, 6);
        chk("R3 write 0", wlog[0], ent(16'h5555, 8'hAA));
        chk("R3 write 1", wlog[1], ent(16'h2AAA, 8'h55));
        chk("R3 write 2", wlog[2], ent(16'h5555, 8'h80));
        chk("R3 write 3", wlog[3], ent(16'h5555, 8'hAA));
        chk("R3 write 4", wlog[4], ent(16'h2AAA, 8'h55));
        if (chip) chk("R4 chip final write", wlog[5], ent(16'h5555, 8'h10));
        else      chk("R3 sector final write", wlog[5], ent(addr, 8'h30));
        chk("R9 erase poll reads", rd_n, pend + 1);
        timing_checks("erase");
    endtask

    task automatic t_timeout();
        start_op(2'd0, 21'h0ABCD, 8'h3C, 1'b0, POLL_LIMIT);
        wait_end();
        chk("R10 timeout err", err, 1);
        chk("R10 timeout no done", done, 0);
        chk("R12 busy low at err", busy, 0);
        repeat (20) @(negedge clk);
        chk("R10 reads at timeout", rd_n, POLL_LIMIT);
        chk("R10 bus quiet after err", fl_ce_n, 1);
    endtask

    task automatic t_last_read();
        start_op(2'd0, 21'h1F000, 8'h81, 1'b1, POLL_LIMIT - 1);
        wait_end();
        chk("R10 match on final read gives done", done, 1);
        chk("R10 match on final read no err", err, 0);
        @(negedge clk);
        chk("R10 reads at final match", rd_n, POLL_LIMIT);
    endtask

    task automatic t_busy_ignore();
        start_op(2'd0, 21'h00777, 8'h5A, 1'b0, 3);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            req_valid = 1'b1; req_cmd = 2'd2;
            chk("R11 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait_end();
        chk("R11 first op completes", done, 1);
        repeat (30) @(negedge clk);
        chk("R11 no extra writes", wr_n, 4);
        chk("R11 no extra reads", rd_n, 4);
        chk("R11 idle afterwards", busy, 0);
    endtask

    task automatic t_reserved();
        start_op(2'd3, 21'h00010, 8'hFF, 1'b1, 0);
        wait_end();
        chk("R13 reserved gives err", err, 1);
        repeat (10) @(negedge clk);
        chk("R13 reserved no writes", wr_n, 0);
        chk("R13 reserved no reads", rd_n, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(21'h12345, 8'hC3, 2);
        t_program(21'h00042, 8'h1E, 0);
        t_erase(1'b0, 21'h0A0000 >> 1, 4);
        t_erase(1'b1, 21'h00000, 1);
        t_last_read();
        t_timeout();
        t_busy_ignore();
        t_reserved();
        @(negedge clk);
        t_reset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule